// File: doc/BRIEF.md
# Dual-clock up/down binary counter

A binary counter with two count strobes, one per direction. A rising edge on the up strobe adds one, but only while the down strobe is held high. A rising edge on the down strobe subtracts one, but only while the up strobe is held high. An active-high clear and an active-low parallel load override counting. Both change the count output combinationally, without waiting for a clock edge, and clear wins over load.

The two strobes are brought onto a fast system clock through synchronizers, and their rising edges are detected there. Two active-low terminal-count outputs let stages be chained without extra logic. The up output goes low while the count is at its maximum and the up strobe is low. The down output goes low while the count is zero and the down strobe is low. Each output returns high on the strobe's rising edge, which is the moment the stage wraps. Wiring these outputs into the strobe inputs of the next stage builds a wider counter.

Top module: `updn_dual_cnt`

## Requirements
- R1: While `clr_i` is 1, `q_o` reads 0 in the same cycle, even if `load_ni` is 0. Both terminal-count outputs read 1 during that time. After `clr_i` falls, the count resumes from 0.
- R2: While `load_ni` is 0 and `clr_i` is 0, `q_o` equals `data_i` in the same cycle. When `load_ni` returns to 1 the value is held. Bit 0 is the least significant bit.
- R3: A rising edge on `up_i` while `dn_i` is 1 increments the count by one. 15 wraps to 0.
- R4: A rising edge on `dn_i` while `up_i` is 1 decrements the count by one. 0 wraps to 15.
- R5: A rising edge on `up_i` while `dn_i` is 0 leaves the count unchanged. Raising `dn_i` afterwards, with `up_i` high, decrements the count.
- R6: Rising edges on `up_i` and `dn_i` in the same cycle leave the count unchanged.
- R7: `tc_up_no` is 0 exactly when the count is 15 and the synchronized `up_i` is 0. Otherwise it is 1.
- R8: `tc_dn_no` is 0 exactly when the count is 0 and the synchronized `dn_i` is 0. Otherwise it is 1.
- R9: A strobe edge that occurs while `load_ni` is 0 or `clr_i` is 1 is dropped. It causes no count once the control is released.
- R10: Two stages form an 8-bit counter when the low stage's `tc_up_no` and `tc_dn_no` drive the high stage's `up_i` and `dn_i`. That counter counts up and down modulo 256 across the wrap.
- R11: While `rst_ni` is 0, the count is 0 and the strobe synchronizers are held at 1, so that releasing reset produces no edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System sampling clock |
| rst_ni | input | 1 | Asynchronous active-low system reset |
| clr_i | input | 1 | Active-high clear, highest priority |
| load_ni | input | 1 | Active-low parallel load |
| data_i | input | WIDTH | Preset value |
| up_i | input | 1 | Count-up strobe |
| dn_i | input | 1 | Count-down strobe |
| q_o | output | WIDTH | Count value |
| tc_up_no | output | 1 | Active-low terminal count, up direction |
| tc_dn_no | output | 1 | Active-low terminal count, down direction |

## Verification
The assertions assume that the count moves by at most one step per system cycle, and that the terminal-count outputs reflect the register only while no load is in progress. Both assumptions rely on the strobes being slow next to the system clock and on strobe edges never coinciding with release of load or clear. The stimulus therefore holds each strobe level for several system cycles. It keeps every strobe edge many cycles away from any change of `clr_i` or `load_ni`. The checks of the opposite-strobe-low case and the simultaneous-edge case are run only while the low stage is away from 0 and 15, so that the high stage of the chain sees no stray edge.

// File: rtl/updn_pkg.sv
package updn_pkg;
  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_INC  = 2'd1,
    STEP_DEC  = 2'd2
  } step_e;

  function automatic step_e pick_step(input logic up_rise, input logic dn_rise,
                                      input logic up_lvl, input logic dn_lvl);
    if (up_rise && !dn_rise && dn_lvl)      return STEP_INC;
    else if (dn_rise && !up_rise && up_lvl) return STEP_DEC;
    else                                    return STEP_HOLD;
  endfunction
endpackage

// File: rtl/updn_edge_sync.sv
module updn_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic lvl_o,
  output logic rise_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q[0] <= 1'b1;
    else         chain_q[0] <= d_i;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q[g] <= 1'b1;
      else         chain_q[g] <= chain_q[g-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b1;
    else         prev_q <= chain_q[STAGES-1];
  end

  assign lvl_o  = chain_q[STAGES-1];
  assign rise_o = chain_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/updn_cnt_core.sv
module updn_cnt_core
  import updn_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             load_ni,
  input  logic [WIDTH-1:0] data_i,
  input  logic             up_rise_i,
  input  logic             dn_rise_i,
  input  logic             up_lvl_i,
  input  logic             dn_lvl_i,
  output logic [WIDTH-1:0] cnt_o,
  output logic [WIDTH-1:0] q_o
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  logic [WIDTH-1:0] cnt_q;
  step_e            step;

  assign step = pick_step(up_rise_i, dn_rise_i, up_lvl_i, dn_lvl_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (clr_i)    cnt_q <= '0;
    else if (!load_ni) cnt_q <= data_i;
    else begin
      unique case (step)
        STEP_INC: cnt_q <= cnt_q + ONE;
        STEP_DEC: cnt_q <= cnt_q - ONE;
        default:  cnt_q <= cnt_q;
      endcase
    end
  end

  // clear and load reach the output without waiting for a clock edge
  always_comb begin
    if (clr_i)         q_o = '0;
    else if (!load_ni) q_o = data_i;
    else               q_o = cnt_q;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/updn_tc_gen.sv
module updn_tc_gen #(
  parameter int WIDTH = 4
) (
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [WIDTH-1:0] cnt_i,
  input  logic             up_lvl_i,
  input  logic             dn_lvl_i,
  output logic             tc_up_no,
  output logic             tc_dn_no
);
  localparam logic [WIDTH-1:0] CNT_MAX = {WIDTH{1'b1}};

  logic hold_hi;
  assign hold_hi  = clr_i | ~rst_ni;
  assign tc_up_no = hold_hi | ~((cnt_i == CNT_MAX) & ~up_lvl_i);
  assign tc_dn_no = hold_hi | ~((cnt_i == '0) & ~dn_lvl_i);
endmodule

// File: rtl/updn_dual_cnt.sv
module updn_dual_cnt #(
  parameter int WIDTH       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             load_ni,
  input  logic [WIDTH-1:0] data_i,
  input  logic             up_i,
  input  logic             dn_i,
  output logic [WIDTH-1:0] q_o,
  output logic             tc_up_no,
  output logic             tc_dn_no
);
  logic             up_lvl, up_rise, dn_lvl, dn_rise;
  logic [WIDTH-1:0] cnt;

  updn_edge_sync #(.STAGES(SYNC_STAGES)) u_sync_up (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(up_i), .lvl_o(up_lvl), .rise_o(up_rise)
  );

  updn_edge_sync #(.STAGES(SYNC_STAGES)) u_sync_dn (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(dn_i), .lvl_o(dn_lvl), .rise_o(dn_rise)
  );

  updn_cnt_core #(.WIDTH(WIDTH)) u_core (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr_i), .load_ni(load_ni),
    .data_i(data_i), .up_rise_i(up_rise), .dn_rise_i(dn_rise),
    .up_lvl_i(up_lvl), .dn_lvl_i(dn_lvl), .cnt_o(cnt), .q_o(q_o)
  );

  updn_tc_gen #(.WIDTH(WIDTH)) u_tc (
    .rst_ni(rst_ni), .clr_i(clr_i), .cnt_i(cnt), .up_lvl_i(up_lvl),
    .dn_lvl_i(dn_lvl), .tc_up_no(tc_up_no), .tc_dn_no(tc_dn_no)
  );
endmodule

// File: rtl/updn_dual_cnt_chk.sv
module updn_dual_cnt_chk #(
  parameter int WIDTH = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             clr_i,
  input logic             load_ni,
  input logic [WIDTH-1:0] data_i,
  input logic [WIDTH-1:0] q_o,
  input logic             tc_up_no,
  input logic             tc_dn_no
);
  localparam logic [WIDTH-1:0] CNT_MAX = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] ONE     = WIDTH'(1);

  a_r1_clear_holds_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(clr_i) && !clr_i && load_ni) |-> (q_o == '0));

  a_r1_clear_tc_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |-> (tc_up_no && tc_dn_no));

  a_r2_load_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(!load_ni && !clr_i) && load_ni && !clr_i) |-> (q_o == $past(data_i)));

  a_r3_single_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(clr_i) && $past(load_ni) && !clr_i && load_ni) |->
      (q_o == $past(q_o) || q_o == $past(q_o) + ONE || q_o == $past(q_o) - ONE));

  a_r7_tc_up_at_max: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tc_up_no && load_ni && $past(load_ni)) |-> (q_o == CNT_MAX));

  a_r8_tc_dn_at_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tc_dn_no && load_ni && $past(load_ni)) |-> (q_o == '0));
endmodule

bind updn_dual_cnt updn_dual_cnt_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr_i), .load_ni(load_ni),
  .data_i(data_i), .q_o(q_o), .tc_up_no(tc_up_no), .tc_dn_no(tc_dn_no)
);

// File: tb/test_updn_dual_cnt.sv
module test_updn_dual_cnt;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       clr = 1'b0;
  logic       load_n = 1'b1;
  logic [3:0] data_lo = '0, data_hi = '0;
  logic       up = 1'b1, dn = 1'b1;
  logic [3:0] q_lo, q_hi;
  logic       tcu_lo, tcd_lo, tcu_hi, tcd_hi;

  int checks = 0;
  int fails = 0;
  logic [7:0] exp_v;

  always #10 clk = ~clk;

  updn_dual_cnt i_updn_dual_cnt (
    .clk_i(clk), .rst_ni(rst_ni), .clr_i(clr), .load_ni(load_n), .data_i(data_lo),
    .up_i(up), .dn_i(dn), .q_o(q_lo), .tc_up_no(tcu_lo), .tc_dn_no(tcd_lo)
  );

  updn_dual_cnt i_updn_dual_cnt_hi (
    .clk_i(clk), .rst_ni(rst_ni), .clr_i(clr), .load_ni(load_n), .data_i(data_hi),
    .up_i(tcu_lo), .dn_i(tcd_lo), .q_o(q_hi), .tc_up_no(tcu_hi), .tc_dn_no(tcd_hi)
  );

  task automatic check(input string tag, input int act, input int expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, expv, $time);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic step_up(input string tag);
    up = 1'b0;
    wait_cyc(4);
    check({tag, " R7 tc_up_no"}, int'(tcu_lo), (exp_v[3:0] == 4'hF) ? 0 : 1);
    check({tag, " R8 tc_dn_no idle"}, int'(tcd_lo), 1);
    up = 1'b1;
    wait_cyc(10);
    exp_v = exp_v + 8'd1;
    check({tag, " R3 R10 up count"}, int'({q_hi, q_lo}), int'(exp_v));
  endtask

  task automatic step_dn(input string tag);
    dn = 1'b0;
    wait_cyc(4);
    check({tag, " R8 tc_dn_no"}, int'(tcd_lo), (exp_v[3:0] == 4'h0) ? 0 : 1);
    check({tag, " R7 tc_up_no idle"}, int'(tcu_lo), 1);
    dn = 1'b1;
    wait_cyc(10);
    exp_v = exp_v - 8'd1;
    check({tag, " R4 R10 down count"}, int'({q_hi, q_lo}), int'(exp_v));
  endtask

  task automatic do_load(input logic [7:0] v);
    data_lo = v[3:0];
    data_hi = v[7:4];
    load_n = 1'b0;
    #1;
    check("R2 load immediate", int'({q_hi, q_lo}), int'(v));
    wait_cyc(3);
    load_n = 1'b1;
    wait_cyc(3);
    check("R2 load held", int'({q_hi, q_lo}), int'(v));
    exp_v = v;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    exp_v = 8'd0;
    wait_cyc(3);
    check("R11 reset count", int'({q_hi, q_lo}), 0);
    check("R11 reset tc_up", int'(tcu_lo), 1);
    check("R11 reset tc_dn", int'(tcd_lo), 1);
    rst_ni = 1'b1;
    wait_cyc(4);
    check("R11 no edge on release", int'({q_hi, q_lo}), 0);

    do_load(8'h37);
    clr = 1'b1;
    #1;
    check("R1 clear immediate", int'(q_lo), 0);
    check("R1 clear tc_up high", int'(tcu_lo), 1);
    check("R1 clear tc_dn high", int'(tcd_lo), 1);
    load_n = 1'b0;
    #1;
    check("R1 clear beats load", int'({q_hi, q_lo}), 0);
    wait_cyc(3);
    load_n = 1'b1;
    wait_cyc(3);
    clr = 1'b0;
    wait_cyc(3);
    check("R1 resume from zero", int'({q_hi, q_lo}), 0);
    exp_v = 8'd0;

    // up sweep across the 8-bit wrap
    for (int i = 0; i < 260; i++) step_up("sweep_up");
    // down sweep across the 8-bit wrap
    for (int i = 0; i < 262; i++) step_dn("sweep_dn");

    do_load(8'h25);
    // R5: up edge while dn low is ignored; then dn rise counts down
    dn = 1'b0;
    wait_cyc(4);
    up = 1'b0;
    wait_cyc(4);
    up = 1'b1;
    wait_cyc(10);
    check("R5 up gated by dn low", int'({q_hi, q_lo}), int'(exp_v));
    dn = 1'b1;
    wait_cyc(10);
    exp_v = exp_v - 8'd1;
    check("R5 dn rise after", int'({q_hi, q_lo}), int'(exp_v));

    // R6: simultaneous edges hold
    up = 1'b0;
    dn = 1'b0;
    wait_cyc(4);
    up = 1'b1;
    dn = 1'b1;
    wait_cyc(10);
    check("R6 simultaneous edges", int'({q_hi, q_lo}), int'(exp_v));

    // R9: edge during load is dropped
    data_lo = 4'h9;
    data_hi = 4'h4;
    load_n = 1'b0;
    wait_cyc(2);
    up = 1'b0;
    wait_cyc(4);
    up = 1'b1;
    wait_cyc(8);
    load_n = 1'b1;
    wait_cyc(10);
    check("R9 edge during load dropped", int'({q_hi, q_lo}), 8'h49);
    exp_v = 8'h49;

    // R9: edge during clear is dropped
    clr = 1'b1;
    wait_cyc(2);
    dn = 1'b0;
    wait_cyc(4);
    dn = 1'b1;
    wait_cyc(8);
    clr = 1'b0;
    wait_cyc(10);
    check("R9 edge during clear dropped", int'({q_hi, q_lo}), 0);
    exp_v = 8'h00;

    step_up("post_clear");
    step_dn("post_clear");
    finish_run();
  end
endmodule